// File: doc/BRIEF.md
# Nonvolatile Store/Recall Command Sequencer

This block sits behind a write-only command register of a battery-free nonvolatile SRAM. It watches register writes and picks out a fixed set of command bytes. Each accepted byte starts a timed nonvolatile operation: a store of the array into the nonvolatile cells, a recall back into the array, a change to the volatile automatic-store setting, or entry into a low-power sleep state. While an operation runs, `busy` blocks SRAM access. The length of the lockout depends on the command class and is set by parameters in clock cycles.

The block keeps a dirty flag that records whether the array was written since the last store or recall. It drives one-cycle start pulses to an external store/recall engine, an active-low hardware-store-busy indication, and a persist pulse after each finished store so that neighbouring registers can latch their nonvolatile shadows. Synchronous reset models power-up. Leaving reset always runs one automatic recall. Sleep ends only through the `wake` input.

Top module: `nvcmd_sequencer`

## Requirements
- R1: While `rst` is high, `busy`=1, `autostore_en`=1, `dirty`=0, `hsb_n`=1, `sleeping`=0, and every pulse output is 0. After `rst` falls, one automatic recall runs: `recall_start` pulses once and `busy` stays high for 1+RECALL_CYC cycles in total, counted from the first cycle without reset.
- R2: Only a write to address CMD_ADDR (0xAA) is decoded. The command bytes are 0x3C store, 0x60 recall, 0x59 automatic-store on, 0x19 automatic-store off and 0xB9 sleep. Any other byte, and any write to another address, changes no output. The register has no read path.
- R3: An accepted store pulses `store_start` for one cycle, in the first busy cycle, and holds `busy` for exactly STORE_CYC cycles. This happens whether `dirty` is set or clear.
- R4: An accepted recall pulses `recall_start` for one cycle and holds `busy` for exactly RECALL_CYC cycles.
- R5: An accepted automatic-store on/off command sets or clears `autostore_en` in the cycle after the write, and holds `busy` for SS_CYC cycles.
- R6: An accepted sleep holds `busy` with `hsb_n`=1 for SS_CYC cycles. If `dirty` is set it then runs a store of STORE_CYC cycles with a `store_start` pulse; if `dirty` is clear it skips the store. The block then enters sleep (`sleeping`=1, `busy`=1). `hsb_n` is 0 from the end of the SS_CYC wait until wake.
- R7: A `wake` pulse while sleeping returns the block to idle in the next cycle (`busy`=0, `sleeping`=0, `hsb_n`=1) and starts no recall. `wake` outside sleep has no effect.
- R8: `sram_wr` while not busy sets `dirty` in the next cycle. `sram_wr` while busy is ignored. Completion of any store or recall clears `dirty`.
- R9: A command-register write while `busy` is high is ignored, and `cmd_rejected` pulses for one cycle in the next cycle.
- R10: `persist` pulses for one cycle in the cycle after the last cycle of every store, including a store triggered by sleep. A recall never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| reg_wr_en | input | 1 | Control-register write strobe |
| reg_addr | input | ADDR_W | Control-register write address |
| reg_wdata | input | 8 | Control-register write byte |
| sram_wr | input | 1 | SRAM array write strobe |
| wake | input | 1 | Leave sleep |
| busy | output | 1 | SRAM access blocked |
| store_start | output | 1 | One-cycle start of a store to the engine |
| recall_start | output | 1 | One-cycle start of a recall to the engine |
| persist | output | 1 | One-cycle pulse after a finished store |
| cmd_rejected | output | 1 | Command write arrived while busy |
| dirty | output | 1 | Array written since last store or recall |
| autostore_en | output | 1 | Volatile automatic-store setting |
| hsb_n | output | 1 | Active-low hardware-store-busy indication |
| sleeping | output | 1 | Block is in sleep |

## Verification
The bench goes after the difference between the unconditional store command and the store that sleep runs only when the array is dirty. A design that tested `dirty` for a plain store would skip a clean store. A design that ignored `dirty` in sleep would waste an extra store and hold `hsb_n` low for too long. Near-miss bytes, bit-reversed opcodes and the wrong address are sent to catch a decoder that matches too loosely. Commands and array writes are placed inside busy windows and inside sleep, where a leaky guard would start a second operation or set `dirty`. Wake is exercised both inside and outside sleep, to catch a design that recalls on wake or treats a stray wake as a command.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;

    localparam logic [7:0] OP_STORE  = 8'h3C;
    localparam logic [7:0] OP_RECALL = 8'h60;
    localparam logic [7:0] OP_AS_ON  = 8'h59;
    localparam logic [7:0] OP_AS_OFF = 8'h19;
    localparam logic [7:0] OP_SLEEP  = 8'hB9;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_STORE,
        CMD_RECALL,
        CMD_AS_ON,
        CMD_AS_OFF,
        CMD_SLEEP
    } cmd_e;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_STORE,
        ST_RECALL,
        ST_SETTLE,
        ST_SLEEP_WAIT,
        ST_SLEEP_STORE,
        ST_ASLEEP
    } state_e;

    typedef struct packed {
        logic store_go;
        logic recall_go;
        logic persist;
        logic reject;
    } pulse_t;

    function automatic cmd_e decode_op(input logic [7:0] b);
        cmd_e c;
        case (b)
            OP_STORE:  c = CMD_STORE;
            OP_RECALL: c = CMD_RECALL;
            OP_AS_ON:  c = CMD_AS_ON;
            OP_AS_OFF: c = CMD_AS_OFF;
            OP_SLEEP:  c = CMD_SLEEP;
            default:   c = CMD_NONE;
        endcase
        return c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nvcmd_decode.sv
module nvcmd_decode
    import nvcmd_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(8'hAA)
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              hit,
    output cmd_e              cmd
);
    always_comb begin
        hit = wr_en && (addr == CMD_ADDR);
        cmd = hit ? decode_op(data) : CMD_NONE;
    end
endmodule

// File: rtl/nvcmd_timer.sv
module nvcmd_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvcmd_dirty.sv
module nvcmd_dirty (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic dirty
);
    always_ff @(posedge clk) begin
        if (rst)       dirty <= 1'b0;
        else if (clr)  dirty <= 1'b0;
        else if (set)  dirty <= 1'b1;
    end
endmodule

// File: rtl/nvcmd_sequencer.sv
module nvcmd_sequencer
    import nvcmd_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CMD_ADDR   = 'hAA,
    parameter int STORE_CYC  = 40,
    parameter int RECALL_CYC = 24,
    parameter int SS_CYC     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              sram_wr,
    input  logic              wake,
    output logic              busy,
    output logic              store_start,
    output logic              recall_start,
    output logic              persist,
    output logic              cmd_rejected,
    output logic              dirty,
    output logic              autostore_en,
    output logic              hsb_n,
    output logic              sleeping
);
    localparam int MAX_CYC = max3(STORE_CYC, RECALL_CYC, SS_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LD_STORE  = CNT_W'(STORE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RECALL = CNT_W'(RECALL_CYC - 1);
    localparam logic [CNT_W-1:0] LD_SS     = CNT_W'(SS_CYC - 1);

    state_e           state_q, state_d;
    logic             asen_q, asen_d;
    pulse_t           pulse_q, pulse_d;
    logic             hit;
    cmd_e             cmd;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             dirty_clr;

    nvcmd_decode #(
        .ADDR_W   (ADDR_W),
        .CMD_ADDR (ADDR_W'(CMD_ADDR))
    ) decode_i (
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .data  (reg_wdata),
        .hit   (hit),
        .cmd   (cmd)
    );

    nvcmd_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    nvcmd_dirty dirty_i (
        .clk   (clk),
        .rst   (rst),
        .set   (sram_wr && !busy),
        .clr   (dirty_clr),
        .dirty (dirty)
    );

    assign busy = (state_q != ST_IDLE);

    always_comb begin
        state_d   = state_q;
        asen_d    = asen_q;
        pulse_d   = '0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        dirty_clr = 1'b0;

        pulse_d.reject = hit && busy;

        case (state_q)
            ST_PWRUP: begin
                state_d           = ST_RECALL;
                tmr_load          = 1'b1;
                tmr_val           = LD_RECALL;
                pulse_d.recall_go = 1'b1;
            end
            ST_IDLE: begin
                case (cmd)
                    CMD_STORE: begin
                        state_d          = ST_STORE;
                        tmr_load         = 1'b1;
                        tmr_val          = LD_STORE;
                        pulse_d.store_go = 1'b1;
                    end
                    CMD_RECALL: begin
                        state_d           = ST_RECALL;
                        tmr_load          = 1'b1;
                        tmr_val           = LD_RECALL;
                        pulse_d.recall_go = 1'b1;
                    end
                    CMD_AS_ON, CMD_AS_OFF: begin
                        state_d  = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = LD_SS;
                        asen_d   = (cmd == CMD_AS_ON);
                    end
                    CMD_SLEEP: begin
                        state_d  = ST_SLEEP_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = LD_SS;
                    end
                    default: ;
                endcase
            end
            ST_STORE: begin
                if (tmr_expired) begin
                    state_d         = ST_IDLE;
                    dirty_clr       = 1'b1;
                    pulse_d.persist = 1'b1;
                end
            end
            ST_RECALL: begin
                if (tmr_expired) begin
                    state_d   = ST_IDLE;
                    dirty_clr = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            ST_SLEEP_WAIT: begin
                if (tmr_expired) begin
                    if (dirty) begin
                        state_d          = ST_SLEEP_STORE;
                        tmr_load         = 1'b1;
                        tmr_val          = LD_STORE;
                        pulse_d.store_go = 1'b1;
                    end else begin
                        state_d = ST_ASLEEP;
                    end
                end
            end
            ST_SLEEP_STORE: begin
                if (tmr_expired) begin
                    state_d         = ST_ASLEEP;
                    dirty_clr       = 1'b1;
                    pulse_d.persist = 1'b1;
                end
            end
            ST_ASLEEP: begin
                if (wake) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PWRUP;
            asen_q  <= 1'b1;
            pulse_q <= '0;
        end else begin
            state_q <= state_d;
            asen_q  <= asen_d;
            pulse_q <= pulse_d;
        end
    end

    assign store_start  = pulse_q.store_go;
    assign recall_start = pulse_q.recall_go;
    assign persist      = pulse_q.persist;
    assign cmd_rejected = pulse_q.reject;
    assign autostore_en = asen_q;
    assign sleeping     = (state_q == ST_ASLEEP);
    assign hsb_n        = !((state_q == ST_SLEEP_STORE) || (state_q == ST_ASLEEP));

endmodule

// File: rtl/nvcmd_sequencer_chk.sv
module nvcmd_sequencer_chk #(
    parameter int ADDR_W   = 8,
    parameter int CMD_ADDR = 'hAA
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              sram_wr,
    input logic              wake,
    input logic              busy,
    input logic              store_start,
    input logic              recall_start,
    input logic              persist,
    input logic              cmd_rejected,
    input logic              dirty,
    input logic              autostore_en,
    input logic              hsb_n,
    input logic              sleeping
);
    logic cmd_wr;
    assign cmd_wr = reg_wr_en && (reg_addr == ADDR_W'(CMD_ADDR));

    AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        store_start |=> !store_start) else $error("store_start too long"); // R3
    AST_STORE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        store_start |-> busy) else $error("store_start outside busy"); // R3
    AST_RECALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        recall_start |=> !recall_start) else $error("recall_start too long"); // R4
    AST_AS_OFF_TAKES: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && reg_wdata == 8'h19) |=> !autostore_en) else $error("as off"); // R5
    AST_AS_ON_TAKES: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && reg_wdata == 8'h59) |=> autostore_en) else $error("as on"); // R5
    AST_HSB_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        !hsb_n |-> busy) else $error("hsb low while idle"); // R6
    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (rst)
        (sleeping && wake) |=> (!busy && hsb_n && !recall_start)) else $error("wake"); // R7
    AST_DIRTY_SET: assert property (@(posedge clk) disable iff (rst)
        (sram_wr && !busy) |=> dirty) else $error("dirty not set"); // R8
    AST_DIRTY_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy && !dirty) |=> !dirty) else $error("dirty set while busy"); // R8
    AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy) |=> cmd_rejected) else $error("no reject"); // R9
    AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        cmd_rejected |-> $past(busy)) else $error("spurious reject"); // R9
    AST_PERSIST_CLEAN: assert property (@(posedge clk) disable iff (rst)
        persist |-> (!dirty && $past(busy))) else $error("persist"); // R10
endmodule

bind nvcmd_sequencer nvcmd_sequencer_chk #(
    .ADDR_W   (ADDR_W),
    .CMD_ADDR (CMD_ADDR)
) chk_i (.*);

// File: tb/nvcmd_sequencer_tb.sv
`timescale 1ns/1ps
module nvcmd_sequencer_tb_top;

    localparam int ST = 40;
    localparam int RC = 24;
    localparam int SS = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       sram_wr = 1'b0;
    logic       wake = 1'b0;
    logic busy, store_start, recall_start, persist, cmd_rejected;
    logic dirty, autostore_en, hsb_n, sleeping;

    int n_chk = 0;
    int n_fail = 0;
    int m_cyc, m_st, m_rc, m_pe, m_hl;

    always #2 clk = ~clk;

    nvcmd_sequencer #(
        .ADDR_W(8), .CMD_ADDR('hAA),
        .STORE_CYC(ST), .RECALL_CYC(RC), .SS_CYC(SS)
    ) dut_i (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .sram_wr(sram_wr), .wake(wake),
        .busy(busy), .store_start(store_start), .recall_start(recall_start),
        .persist(persist), .cmd_rejected(cmd_rejected), .dirty(dirty),
        .autostore_en(autostore_en), .hsb_n(hsb_n), .sleeping(sleeping)
    );

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
        logic       pre_dirty;
        logic [7:0] cyc;
        logic [1:0] stores;
        logic [1:0] recalls;
        logic       pers;
        logic       as_after;
        logic       dirty_after;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{8'hAA, 8'h3C, 1'b0, 8'(ST), 2'd1, 2'd0, 1'b1, 1'b1, 1'b0},
        '{8'hAA, 8'h3C, 1'b1, 8'(ST), 2'd1, 2'd0, 1'b1, 1'b1, 1'b0},
        '{8'hAA, 8'h60, 1'b1, 8'(RC), 2'd0, 2'd1, 1'b0, 1'b1, 1'b0},
        '{8'hAA, 8'h19, 1'b1, 8'(SS), 2'd0, 2'd0, 1'b0, 1'b0, 1'b1},
        '{8'hAA, 8'h00, 1'b0, 8'd0,   2'd0, 2'd0, 1'b0, 1'b0, 1'b1},
        '{8'hAB, 8'h59, 1'b0, 8'd0,   2'd0, 2'd0, 1'b0, 1'b0, 1'b1},
        '{8'hAA, 8'h59, 1'b0, 8'(SS), 2'd0, 2'd0, 1'b0, 1'b1, 1'b1},
        '{8'hAA, 8'hFF, 1'b0, 8'd0,   2'd0, 2'd0, 1'b0, 1'b1, 1'b1},
        '{8'hAA, 8'hC3, 1'b0, 8'd0,   2'd0, 2'd0, 1'b0, 1'b1, 1'b1},
        '{8'hAA, 8'hB8, 1'b0, 8'd0,   2'd0, 2'd0, 1'b0, 1'b1, 1'b1},
        '{8'hAA, 8'h60, 1'b0, 8'(RC), 2'd0, 2'd1, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue_cmd(input logic [7:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
    endtask

    task automatic sram_write();
        sram_wr = 1'b1;
        @(negedge clk);
        sram_wr = 1'b0;
    endtask

    task automatic measure(input bit stop_at_sleep);
        m_cyc = 0; m_st = 0; m_rc = 0; m_pe = 0; m_hl = 0;
        for (int g = 0; g < 1000; g++) begin
            if (!busy || (stop_at_sleep && sleeping)) break;
            m_cyc++;
            m_st += int'(store_start);
            m_rc += int'(recall_start);
            m_pe += int'(persist);
            m_hl += int'(!hsb_n);
            @(negedge clk);
        end
        m_pe += int'(persist);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy in reset", busy, 1);
        check("R1 autostore in reset", autostore_en, 1);
        check("R1 dirty in reset", dirty, 0);
        check("R1 hsb_n in reset", hsb_n, 1);
        check("R1 pulses in reset", store_start + recall_start + persist + cmd_rejected + sleeping, 0);
        rst = 1'b0;
        measure(1'b0);
        check("R1 power-up recall busy", m_cyc, 1 + RC);
        check("R1 power-up recall pulses", m_rc, 1);
        check("R1 power-up no store", m_st, 0);

        // R2/R3/R4/R5/R10 table walk
        foreach (VECS[i]) begin
            if (VECS[i].pre_dirty && !dirty) sram_write();
            issue_cmd(VECS[i].addr, VECS[i].data);
            measure(1'b0);
            check("R2/R3/R4/R5 busy cycles", m_cyc, int'(VECS[i].cyc));
            check("R3 store_start count", m_st, int'(VECS[i].stores));
            check("R4 recall_start count", m_rc, int'(VECS[i].recalls));
            check("R10 persist count", m_pe, int'(VECS[i].pers));
            check("R5 autostore after", autostore_en, int'(VECS[i].as_after));
            check("R8 dirty after", dirty, int'(VECS[i].dirty_after));
        end

        // R8 array write sets dirty, write during busy ignored
        sram_write();
        check("R8 dirty set", dirty, 1);
        issue_cmd(8'hAA, 8'h3C);
        measure(1'b0);
        issue_cmd(8'hAA, 8'h59);
        sram_write();
        check("R8 write while busy", dirty, 0);
        measure(1'b0);
        check("R8 dirty stays clear", dirty, 0);

        // R9 command during busy
        issue_cmd(8'hAA, 8'h3C);
        issue_cmd(8'hAA, 8'h60);
        check("R9 cmd_rejected pulse", cmd_rejected, 1);
        measure(1'b0);
        check("R9 store unaffected", m_cyc, ST - 1);
        check("R9 no recall started", m_rc, 0);
        check("R9 reject one cycle", cmd_rejected, 0);

        // R6 dirty sleep
        sram_write();
        issue_cmd(8'hAA, 8'hB9);
        measure(1'b1);
        check("R6 dirty sleep busy", m_cyc, SS + ST);
        check("R6 dirty sleep store", m_st, 1);
        check("R6 hsb low cycles", m_hl, ST);
        check("R10 persist after sleep store", persist, 1);
        check("R6 asleep", sleeping, 1);
        check("R6 hsb low asleep", hsb_n, 0);
        check("R8 dirty cleared by sleep store", dirty, 0);
        issue_cmd(8'hAA, 8'h3C);
        check("R9 reject while asleep", cmd_rejected, 1);
        repeat (3) @(negedge clk);
        check("R6 still asleep", sleeping, 1);
        check("R6 no store while asleep", store_start, 0);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        check("R7 wake busy", busy, 0);
        check("R7 wake sleeping", sleeping, 0);
        check("R7 wake hsb_n", hsb_n, 1);
        check("R7 wake no recall", recall_start, 0);

        // R6 clean sleep skips store
        issue_cmd(8'hAA, 8'hB9);
        measure(1'b1);
        check("R6 clean sleep busy", m_cyc, SS);
        check("R6 clean sleep no store", m_st, 0);
        check("R6 clean sleep hsb high in wait", m_hl, 0);
        check("R10 no persist clean sleep", persist, 0);
        check("R6 clean asleep", sleeping, 1);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        check("R7 clean wake", busy, 0);

        // R7 wake while idle
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        @(negedge clk);
        check("R7 idle wake busy", busy, 0);
        check("R7 idle wake pulses", store_start + recall_start + sleeping, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule